// File: doc/BRIEF.md
# Serial Port Hardware Flow Controller

This block sits between the character transmitter/receiver of a serial port and the port's modem-control pins. A 5-bit mode word picks the lines used for handshaking. Two incoming lines, CTS and CD, can gate when the transmitter may start a character. Two outgoing lines, RTS and DTR, can tell the far end to pause when the local receive buffer fills. A further mode bit throttles input by stopping the outgoing clock that the far end uses to send data.

The transmitter starts a new character only in a cycle where `tx_ready_o` is high. A character already being shifted out always finishes; gating affects only the next start. The receive buffer reports its fill level. An internal stop condition with hysteresis drives the throttle lines from that level.

Mode changes arrive through a write port and follow one of three policies:
- apply at once;
- apply after the transmit queue has drained;
- apply after the transmit queue has drained and pending receive data has been flushed.

While a deferred change is pending, the port is busy and refuses new writes.

Top module: `sp_hw_flow`

## Requirements
- R1: After reset, `mode_o` is 0, `rts_o`, `dtr_o`, `tx_ready_o`, `cfg_busy_o`, `cfg_err_o` and `rx_flush_o` are low while `port_en_i` is low.
- R2: With mode bit 1 set, `tx_ready_o` is high only while `port_en_i` is high and the synchronized CTS is high. A change on `cts_i` reaches `tx_ready_o` after exactly two rising clock edges.
- R3: With mode bit 3 set, `tx_ready_o` is additionally gated by the synchronized CD in the same way, with the same two-edge latency.
- R4: With neither mode bit 1 nor bit 3 set, `tx_ready_o` equals `port_en_i`, whatever CTS and CD do.
- R5: With mode bit 0 set, `rts_o` is low while the receive stop condition is active. With mode bit 2 set, `dtr_o` behaves the same way.
- R6: While `port_en_i` is high, a line whose throttle bit is clear stays high. While `port_en_i` is low, both `rts_o` and `dtr_o` are low.
- R7: The stop condition becomes active one edge after `rx_level_i` is sampled at or above `HI_LVL`. It clears one edge after a sample at or below `LO_LVL`, and holds its value for levels in between.
- R8: `oclk_en_o` is high when `ext_clk_i` is high, unless mode bit 4 is set and the stop condition is active. When `ext_clk_i` is low, `oclk_en_o` is low and mode bit 4 has no effect.
- R9: An accepted write that sets both bits 0 and 2, or both bits 1 and 3, leaves `mode_o` unchanged and sets `cfg_err_o` after that edge. A legal accepted write clears `cfg_err_o`.
- R10: A write with policy 0 (`cfg_policy_i` = 2'd0) changes `mode_o` at the same edge that samples it.
- R11: A write with policy 1 raises `cfg_busy_o` and keeps `mode_o` unchanged until an edge samples `txq_empty_i` high. At that edge the new mode is applied and busy drops.
- R12: A write with policy 2 or 3 (`cfg_policy_i[1]` set) waits for `txq_empty_i` in the same way. It then holds `rx_flush_o` high for exactly one cycle with the mode still unchanged, and applies the mode and drops busy at the next edge.
- R13: A write while `cfg_busy_o` is high is ignored: it changes neither `mode_o` nor `cfg_err_o`, and the pending update still completes with its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Port open |
| tx_ready_o | output | 1 | Transmitter may start a character |
| txq_empty_i | input | 1 | Transmit queue and shifter are empty |
| rx_level_i | input | LVL_W | Receive buffer fill level |
| rx_flush_o | output | 1 | One-cycle request to discard pending receive data |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| cd_i | input | 1 | Carrier-detect pin, asynchronous |
| rts_o | output | 1 | Request-to-send pin |
| dtr_o | output | 1 | Terminal-ready pin |
| ext_clk_i | input | 1 | Port is set to drive an outgoing clock |
| oclk_en_o | output | 1 | Outgoing clock enable |
| cfg_we_i | input | 1 | Mode write strobe |
| cfg_mode_i | input | 5 | New mode word |
| cfg_policy_i | input | 2 | Apply policy: 0 now, 1 after drain, 2 or 3 after drain and flush |
| cfg_busy_o | output | 1 | Deferred update pending; writes refused |
| cfg_err_o | output | 1 | Last accepted write was an illegal combination |
| mode_o | output | 5 | Mode in force |

## Verification
CTS and CD reach `tx_ready_o` two edges after a pin change. The fill-level stop condition, and through it `rts_o`, `dtr_o` and `oclk_en_o`, follows one edge after the level is sampled. A policy-0 write shows on `mode_o` one edge after it is sampled. The drain and flush policies complete one edge, or two edges with the flush cycle, after `txq_empty_i` is first sampled high.

The bench drives every input on the falling edge and checks on the next falling edge. A reference model, advanced on the rising edge from the same inputs, supplies the pin pipeline and stop state for the random phase. The directed checks count the edges stated above before sampling.

// File: rtl/sp_flow_pkg.sv
package sp_flow_pkg;
  localparam int MODE_W = 5;
  localparam int M_RTS = 0;
  localparam int M_CTS = 1;
  localparam int M_DTR = 2;
  localparam int M_CD  = 3;
  localparam int M_ISO = 4;

  typedef logic [MODE_W-1:0] mode_t;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_WAIT  = 2'd1,
    CS_FLUSH = 2'd2
  } cfg_st_e;

  localparam logic [1:0] POL_NOW = 2'd0;

  function automatic logic mode_illegal(mode_t m);
    return (m[M_RTS] & m[M_DTR]) | (m[M_CTS] & m[M_CD]);
  endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sp_rx_stop.sv
module sp_rx_stop #(
  parameter int LVL_W  = 6,
  parameter int HI_LVL = 48,
  parameter int LO_LVL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  output logic             stop_o
);
  localparam logic [LVL_W-1:0] HI = LVL_W'(HI_LVL);
  localparam logic [LVL_W-1:0] LO = LVL_W'(LO_LVL);

  logic stop_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              stop_q <= 1'b0;
    else if (level_i >= HI)   stop_q <= 1'b1;
    else if (level_i <= LO)   stop_q <= 1'b0;

  assign stop_o = stop_q;

  // R7: between thresholds the condition holds
  a_r7_hold_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && level_i > LO) |=> stop_q);
  a_r7_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_q && level_i < HI) |=> !stop_q);
endmodule

// File: rtl/sp_cfg_apply.sv
module sp_cfg_apply
  import sp_flow_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  mode_t      mode_i,
  input  logic [1:0] policy_i,
  input  logic       txq_empty_i,
  output mode_t      mode_o,
  output logic       busy_o,
  output logic       err_o,
  output logic       flush_o
);
  cfg_st_e st_q;
  mode_t   mode_q, pend_q;
  logic    pflush_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= CS_IDLE;
      mode_q   <= '0;
      pend_q   <= '0;
      pflush_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (st_q)
        CS_IDLE: if (we_i) begin
          if (mode_illegal(mode_i)) begin
            err_q <= 1'b1;
          end else begin
            err_q <= 1'b0;
            if (policy_i == POL_NOW) begin
              mode_q <= mode_i;
            end else begin
              pend_q   <= mode_i;
              pflush_q <= policy_i[1];
              st_q     <= CS_WAIT;
            end
          end
        end
        CS_WAIT: if (txq_empty_i) begin
          if (pflush_q) st_q <= CS_FLUSH;
          else begin
            mode_q <= pend_q;
            st_q   <= CS_IDLE;
          end
        end
        CS_FLUSH: begin
          mode_q <= pend_q;
          st_q   <= CS_IDLE;
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign busy_o  = (st_q != CS_IDLE);
  assign err_o   = err_q;
  assign flush_o = (st_q == CS_FLUSH);

  a_r9_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_illegal(mode_q));
  a_r11_hold_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CS_WAIT && !txq_empty_i) |=> ($stable(mode_q) && busy_o));
  a_r12_flush_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (!flush_o && !busy_o && mode_q == $past(pend_q)));
  a_r13_busy_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(err_q));
endmodule

// File: rtl/sp_hw_flow.sv
module sp_hw_flow
  import sp_flow_pkg::*;
#(
  parameter int LVL_W       = 6,
  parameter int HI_LVL      = 48,
  parameter int LO_LVL      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  output logic              tx_ready_o,
  input  logic              txq_empty_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic              rx_flush_o,
  input  logic              cts_i,
  input  logic              cd_i,
  output logic              rts_o,
  output logic              dtr_o,
  input  logic              ext_clk_i,
  output logic              oclk_en_o,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [1:0]        cfg_policy_i,
  output logic              cfg_busy_o,
  output logic              cfg_err_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [1:0] line_s;
  logic       cts_s, cd_s, stop;
  mode_t      mode;

  sp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({cd_i, cts_i}), .q_o(line_s));
  assign cts_s = line_s[0];
  assign cd_s  = line_s[1];

  sp_rx_stop #(.LVL_W(LVL_W), .HI_LVL(HI_LVL), .LO_LVL(LO_LVL)) u_stop (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(rx_level_i), .stop_o(stop));

  sp_cfg_apply u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .mode_i     (cfg_mode_i),
    .policy_i   (cfg_policy_i),
    .txq_empty_i(txq_empty_i),
    .mode_o     (mode),
    .busy_o     (cfg_busy_o),
    .err_o      (cfg_err_o),
    .flush_o    (rx_flush_o)
  );

  // only the next start is blocked; a running character finishes
  assign tx_ready_o = port_en_i & (~mode[M_CTS] | cts_s) & (~mode[M_CD] | cd_s);
  // unselected lines stay asserted for connectivity
  assign rts_o      = port_en_i & ~(mode[M_RTS] & stop);
  assign dtr_o      = port_en_i & ~(mode[M_DTR] & stop);
  assign oclk_en_o  = ext_clk_i & ~(mode[M_ISO] & stop);
  assign mode_o     = mode;

  a_r2_cts_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[M_CTS] && !cts_s) |-> !tx_ready_o);
  a_r3_cd_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[M_CD] && !cd_s) |-> !tx_ready_o);
  a_r5_rts_throttle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[M_RTS] && stop) |-> !rts_o);
  a_r6_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> (!rts_o && !dtr_o && !tx_ready_o));
  a_r8_no_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_clk_i |-> !oclk_en_o);
endmodule

// File: tb/sim_sp_hw_flow.sv
`timescale 1ns/1ps
module sim_sp_hw_flow;
  localparam int LVL_W = 6;
  localparam int HI = 48;
  localparam int LO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 0, txq_empty = 1, cts = 0, cd = 0, ext = 0, we = 0;
  logic [LVL_W-1:0] level = '0;
  logic [4:0] cmode = '0;
  logic [1:0] cpol = '0;
  logic tx_ready, rx_flush, rts, dtr, oclk, busy, err;
  logic [4:0] mode;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sp_hw_flow #(.LVL_W(LVL_W), .HI_LVL(HI), .LO_LVL(LO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .tx_ready_o(tx_ready),
    .txq_empty_i(txq_empty), .rx_level_i(level), .rx_flush_o(rx_flush),
    .cts_i(cts), .cd_i(cd), .rts_o(rts), .dtr_o(dtr), .ext_clk_i(ext),
    .oclk_en_o(oclk), .cfg_we_i(we), .cfg_mode_i(cmode), .cfg_policy_i(cpol),
    .cfg_busy_o(busy), .cfg_err_o(err), .mode_o(mode));

  // reference model of pin pipeline and stop condition
  logic m_c1, m_c2, m_d1, m_d2, m_stop;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) {m_c1, m_c2, m_d1, m_d2, m_stop} <= '0;
    else begin
      m_c1 <= cts; m_c2 <= m_c1;
      m_d1 <= cd;  m_d2 <= m_d1;
      if (level >= HI) m_stop <= 1'b1;
      else if (level <= LO) m_stop <= 1'b0;
    end

  function automatic logic exp_ready(logic [4:0] m);
    return port_en & (!m[1] | m_c2) & (!m[3] | m_d2);
  endfunction
  function automatic logic exp_line(logic [4:0] m, int b);
    return port_en & !(m[b] & m_stop);
  endfunction
  function automatic logic exp_oclk(logic [4:0] m);
    return ext & !(m[4] & m_stop);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [4:0] m, logic [1:0] p);
    cmode = m; cpol = p; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [4:0] em;
    void'($urandom(32'd4711));
    step(2);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 rts", rts, 0); chk("R1 dtr", dtr, 0);
    chk("R1 ready", tx_ready, 0); chk("R1 busy", busy, 0);
    chk("R1 err", err, 0); chk("R1 flush", rx_flush, 0);

    port_en = 1; step();
    chk("R4 ready no gate", tx_ready, 1);
    chk("R6 rts open", rts, 1); chk("R6 dtr open", dtr, 1);

    write(5'b00011, 2'd0);
    chk("R10 immediate", mode, 5'b00011);
    chk("R2 cts low gates", tx_ready, 0);
    cts = 1; step();
    chk("R2 one edge", tx_ready, 0);
    step();
    chk("R2 two edges", tx_ready, 1);
    cts = 0; step();
    chk("R2 drop one edge", tx_ready, 1);
    step();
    chk("R2 drop two edges", tx_ready, 0);

    write(5'b00101, 2'd0);
    chk("R9 err set", err, 1); chk("R9 mode kept", mode, 5'b00011);
    write(5'b01010, 2'd0);
    chk("R9 illegal gate pair", err, 1); chk("R9 mode kept 2", mode, 5'b00011);

    level = HI[LVL_W-1:0]; step();
    chk("R5 rts throttled", rts, 0); chk("R6 dtr stays", dtr, 1);
    level = 6'd30; step();
    chk("R7 hold between", rts, 0);
    level = LO[LVL_W-1:0]; step();
    chk("R7 release", rts, 1);

    write(5'b10001, 2'd0);
    chk("R9 legal clears err", err, 0);
    ext = 1; level = 6'd60; step();
    chk("R8 clock stopped", oclk, 0);
    ext = 0; step();
    chk("R8 no ext clock", oclk, 0);
    ext = 1; level = 6'd0; step();
    chk("R8 clock runs", oclk, 1);

    write(5'b01000, 2'd0);
    cd = 0; step(2);
    chk("R3 cd gates", tx_ready, 0);
    cd = 1; step();
    chk("R3 one edge", tx_ready, 0);
    step();
    chk("R3 two edges", tx_ready, 1);

    txq_empty = 0;
    write(5'b01100, 2'd1);
    chk("R11 busy", busy, 1); chk("R11 mode held", mode, 5'b01000);
    write(5'b00000, 2'd0);
    chk("R13 ignored", mode, 5'b01000); chk("R13 still busy", busy, 1);
    write(5'b00101, 2'd0);
    chk("R13 err untouched", err, 0);
    step(3);
    chk("R11 still held", mode, 5'b01000);
    txq_empty = 1; step();
    chk("R11 applied", mode, 5'b01100); chk("R11 busy drop", busy, 0);

    txq_empty = 0;
    write(5'b00010, 2'd2);
    chk("R12 busy", busy, 1); chk("R12 no flush yet", rx_flush, 0);
    step(2);
    txq_empty = 1; step();
    chk("R12 flush pulse", rx_flush, 1); chk("R12 mode held", mode, 5'b01100);
    step();
    chk("R12 flush end", rx_flush, 0); chk("R12 applied", mode, 5'b00010);
    chk("R12 busy drop", busy, 0);

    // random phase
    em = mode;
    for (int i = 0; i < 3000; i++) begin
      if (i % 150 == 0) begin
        logic [4:0] nm;
        nm = 5'($urandom);
        if (nm[0] & nm[2]) nm[2] = 1'b0;
        if (nm[1] & nm[3]) nm[3] = 1'b0;
        write(nm, 2'd0);
        em = nm;
        chk("R10 random write", mode, em);
      end
      cts = 1'($urandom); cd = 1'($urandom); ext = 1'($urandom);
      level = LVL_W'($urandom);
      step();
      chk("R2 R3 R4 ready", tx_ready, exp_ready(em));
      chk("R5 R6 rts", rts, exp_line(em, 0));
      chk("R5 R6 dtr", dtr, exp_line(em, 2));
      chk("R7 R8 oclk", oclk, exp_oclk(em));
    end

    port_en = 0; step();
    chk("R6 closed rts", rts, 0); chk("R6 closed dtr", dtr, 0);
    finish_run();
  end
endmodule